// File: doc/BRIEF.md
# CRC Folding Constant Generator

This block computes the multiplier constants that a carry-less-multiply CRC folding datapath needs. The caller supplies a generator polynomial, a CRC width of 16, 32 or 64 bits, an exponent, and a choice of bit order (plain or reflected). The engine starts from the remainder 1 and multiplies it by x once per clock, reducing modulo P whenever a coefficient leaves the width. The result is x^e mod P for an effective exponent e, where e is derived from the requested exponent and the mode.

The remainder is then placed in a 64-bit word. The placement depends on where the folding multiplier will put its product. In plain order the constant is left-justified, which is the same as multiplying it by a power of x. In reflected order it is bit-reversed and, for widths below 64, moved up one position to make up for a product that sits one bit low. A 64-bit reflected constant cannot take that extra position, so the exponent is lowered by one instead. A 64-bit plain constant may need 65 bits; the bit above the word comes out on its own flag.

A single-cycle start pulse captures every input and begins a run. Done pulses once when the result is ready. The result outputs keep their value until the next run completes.

Top module: `crc_fold_const_gen`

## Requirements
- R1: `width_sel` selects the CRC width W: code 0 gives 16, code 1 gives 32, code 2 gives 64. `poly` carries the low W coefficients of P, bit i being the coefficient of x^i, and the x^W term is implied. Code 3 is reserved and makes the run end with an error (see R9).
- R2: With `reflect`=0 and W<64, the effective exponent is e = a−W, and `const_word` = (x^e mod P) shifted left by 64−W bits.
- R3: For W=32, `poly`=0x04C11DB7, `reflect`=0 and `exponent`=608, `const_word` is 0x8833794C00000000.
- R4: With `reflect`=1 and W<64, e = a. `const_word` holds x^e mod P bit-reversed over W bits and shifted left by one, so only bits W down to 1 can be set.
- R5: With `reflect`=1 and W=64, e = a−1, and `const_word` is x^e mod P bit-reversed over 64 bits, with no shift.
- R6: With `reflect`=0 and W=64, e = a−64. The result is the 65-bit value x·(x^(e−1) mod P), or 1 when e=0. Its low 64 bits go to `const_word` and bit 64 goes to `top_term`. `top_term` is 0 in every other mode.
- R7: `busy` rises in the clock after `start` is sampled high. `done` is high for exactly one cycle, e+1 clocks after that sample, and `busy` is low from that same cycle.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The run in progress finishes with its own inputs and its own timing.
- R9: A negative effective exponent (a<W in plain mode, or a=0 in 64-bit reflected mode) or a reserved width code ends the run one clock after start. In that case `err`=1, `const_word`=0 and `top_term`=0. `err` is 0 after every valid run.
- R10: After reset, `busy`, `done`, `err` and `top_term` are 0 and `const_word` is 0.
- R11: `const_word`, `top_term` and `err` keep their value from one completed run until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| poly | input | 64 | Low W coefficients of P |
| width_sel | input | 2 | CRC width code |
| exponent | input | 16 | Requested exponent a |
| reflect | input | 1 | 1 = reflected bit order |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle result strobe |
| const_word | output | 64 | Packed constant |
| top_term | output | 1 | x^64 coefficient, 64-bit plain mode |
| err | output | 1 | Last run had an invalid request |

## Verification
The assertions assume that `start` is a clean synchronous pulse and that the configuration captured at start stays in force until done. They also rely on the width code seen at done being the one the run used. The stimulus pulses start for one clock and only from idle, except in one deliberate case where start is pulsed mid-run to exercise R8. Random runs cover all four width codes, both bit orders and exponents up to about 700. This range includes values on both sides of the negative-exponent limit, while keeping each run short.

// File: rtl/crc_fold_pkg.sv
// Shared definitions for the CRC folding constant generator.
// Assumes constants never exceed 64 bits plus one overflow term.
package crc_fold_pkg;
    parameter int unsigned WORD_W = 64;

    typedef enum logic [1:0] {
        WSEL_16  = 2'd0,
        WSEL_32  = 2'd1,
        WSEL_64  = 2'd2,
        WSEL_RSV = 2'd3
    } wsel_e;

    // Width in bits for a width code; 0 marks the reserved code.
    function automatic logic [6:0] width_of(input logic [1:0] code);
        case (code)
            WSEL_16: width_of = 7'd16;
            WSEL_32: width_of = 7'd32;
            WSEL_64: width_of = 7'd64;
            default: width_of = 7'd0;
        endcase
    endfunction
endpackage

// File: rtl/crc_fold_ctrl.sv
// Run controller: captures the request at start, derives the effective
// exponent, counts steps and issues the finish strobe.
// Assumes start is synchronous; start is ignored while busy.
module crc_fold_ctrl
    import crc_fold_pkg::*;
#(
    parameter int unsigned EXP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       width_sel,
    input  logic [EXP_W-1:0] exponent,
    input  logic             reflect,
    output logic             busy,
    output logic             done,
    output logic             err_pend,
    output logic [6:0]       cfg_w,
    output logic             cfg_refl,
    output logic             load,
    output logic             step,
    output logic             last_step,
    output logic             finish
);
    logic [EXP_W-1:0] cnt_q;
    logic             busy_q, done_q, err_q, refl_q;
    logic [6:0]       w_q;

    logic [6:0]       w_in;
    logic [EXP_W-1:0] sub_in;
    logic             neg_in;

    // Effective exponent offset for the requested mode.
    always_comb begin
        w_in = width_of(width_sel);
        if (reflect)
            sub_in = (w_in == 7'd64) ? EXP_W'(1) : '0;
        else
            sub_in = EXP_W'(w_in);
        neg_in = (exponent < sub_in) || (w_in == 7'd0);
    end

    // Run state: idle capture, step countdown, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            refl_q <= 1'b0;
            w_q    <= 7'd0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    w_q    <= w_in;
                    refl_q <= reflect;
                    err_q  <= neg_in;
                    cnt_q  <= neg_in ? '0 : (exponent - sub_in);
                end
            end else if (cnt_q == '0) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign err_pend  = err_q;
    assign cfg_w     = w_q;
    assign cfg_refl  = refl_q;
    assign load      = !busy_q && start;
    assign step      = busy_q && (cnt_q != '0);
    assign last_step = step && (cnt_q == EXP_W'(1));
    assign finish    = busy_q && (cnt_q == '0);

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(w_q) && $stable(refl_q))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q))); // R7
endmodule

// File: rtl/crc_fold_rem.sv
// Remainder stepper: multiplies the remainder by x per step and reduces
// by P unless told not to. An unreduced overflow goes to top_bit.
// Assumes width is 16, 32 or 64 whenever step is high.
module crc_fold_rem
    import crc_fold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] poly,
    input  logic [6:0]        width,
    input  logic              load,
    input  logic              step,
    input  logic              noreduce,
    output logic [WORD_W-1:0] rem,
    output logic              top_bit
);
    logic [WORD_W-1:0] rem_q, mask, shifted;
    logic              top_q, msb;

    // Mask of the live remainder bits and the next remainder.
    always_comb begin
        mask    = (width >= 7'd64) ? '1 : ((WORD_W'(1) << width) - 1'b1);
        msb     = (width == 7'd0) ? 1'b0 : rem_q[width - 7'd1];
        shifted = (rem_q << 1) & mask;
        if (msb && !noreduce)
            shifted = shifted ^ (poly & mask);
    end

    // Remainder register: loads 1, then steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            top_q <= 1'b0;
        end else if (load) begin
            rem_q <= WORD_W'(1);
            top_q <= 1'b0;
        end else if (step) begin
            rem_q <= shifted;
            if (msb && noreduce)
                top_q <= 1'b1;
        end
    end

    assign rem     = rem_q;
    assign top_bit = top_q;
endmodule

// File: rtl/crc_fold_pack.sv
// Output packer: places the remainder for the chosen bit order.
// Assumes rem has no bits set at or above width.
module crc_fold_pack
    import crc_fold_pkg::*;
(
    input  logic [WORD_W-1:0] rem,
    input  logic [6:0]        width,
    input  logic              refl,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] rev;

    // Bit reversal over the active width.
    always_comb begin
        rev = '0;
        for (int i = 0; i < WORD_W; i++)
            if (i < int'(width))
                rev[int'(width) - 1 - i] = rem[i];
    end

    // Mode placement of the constant.
    always_comb begin
        if (width == 7'd0)
            word = '0;
        else if (!refl)
            word = rem << (7'd64 - width);
        else if (width < 7'd64)
            word = rev << 1;
        else
            word = rev;
    end
endmodule

// File: rtl/crc_fold_const_gen.sv
// Top level of the CRC folding constant generator: controller, stepper,
// packer and result registers, which are loaded on the finish strobe.
// Assumes a single-cycle start pulse.
module crc_fold_const_gen
    import crc_fold_pkg::*;
#(
    parameter int unsigned EXP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] poly,
    input  logic [1:0]        width_sel,
    input  logic [EXP_W-1:0]  exponent,
    input  logic              reflect,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] const_word,
    output logic              top_term,
    output logic              err
);
    logic [WORD_W-1:0] poly_q, rem, packed_w;
    logic [6:0]        cfg_w;
    logic              cfg_refl, load, step, last_step, finish, err_pend, rem_top;
    logic              noreduce;
    logic [WORD_W-1:0] word_q;
    logic              top_q, err_q;

    crc_fold_ctrl #(.EXP_W(EXP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
        .exponent(exponent), .reflect(reflect), .busy(busy), .done(done),
        .err_pend(err_pend), .cfg_w(cfg_w), .cfg_refl(cfg_refl), .load(load),
        .step(step), .last_step(last_step), .finish(finish)
    );

    // Polynomial capture at start.
    always_ff @(posedge clk) begin
        if (!rst_n)    poly_q <= '0;
        else if (load) poly_q <= poly;
    end

    assign noreduce = last_step && !cfg_refl && (cfg_w == 7'd64);

    crc_fold_rem u_rem (
        .clk(clk), .rst_n(rst_n), .poly(poly_q), .width(cfg_w), .load(load),
        .step(step), .noreduce(noreduce), .rem(rem), .top_bit(rem_top)
    );

    crc_fold_pack u_pack (
        .rem(rem), .width(cfg_w), .refl(cfg_refl), .word(packed_w)
    );

    // Result registers, updated only on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            top_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (finish) begin
            word_q <= err_pend ? '0 : packed_w;
            top_q  <= err_pend ? 1'b0 : rem_top;
            err_q  <= err_pend;
        end
    end

    assign const_word = word_q;
    assign top_term   = top_q;
    assign err        = err_q;

    AST_TOP_ONLY_PLAIN64: assert property (@(posedge clk) disable iff (!rst_n)
        (done && top_term) |-> (!cfg_refl && cfg_w == 7'd64)); // R6
    AST_ERR_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (const_word == '0 && !top_term)); // R9
    AST_REFL_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && cfg_refl && cfg_w < 7'd64) |-> ((const_word >> (cfg_w + 7'd1)) == '0)); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(finish) && $past(rst_n)) |-> ($stable(const_word) && $stable(err))); // R11
endmodule

// File: tb/sim_crc_fold_const_gen.sv
`timescale 1ns/1ps
module sim_crc_fold_const_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] poly = '0;
    logic [1:0]  width_sel = '0;
    logic [15:0] exponent = '0;
    logic        reflect = 1'b0;
    logic        busy, done, top_term, err;
    logic [63:0] const_word;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    crc_fold_const_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .poly(poly),
        .width_sel(width_sel), .exponent(exponent), .reflect(reflect),
        .busy(busy), .done(done), .const_word(const_word),
        .top_term(top_term), .err(err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result from the requirements.
    function automatic void model(input logic [63:0] p, input logic [1:0] ws, input int a,
                                  input bit rf, output logic [63:0] word, output bit top,
                                  output bit er, output int lat);
        int w, sub, e;
        logic [64:0] m;
        logic [63:0] r, rv;
        bit msb;
        w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 32 : (ws == 2'd2) ? 64 : 0;
        word = '0; top = 0; er = 0; lat = 1;
        sub = rf ? ((w == 64) ? 1 : 0) : w;
        if (w == 0 || a < sub) begin er = 1; return; end
        e = a - sub;
        lat = e + 1;
        m = (65'd1 << w) - 65'd1;
        r = 64'd1;
        for (int i = 0; i < e; i++) begin
            msb = r[w-1];
            r = (r << 1) & m[63:0];
            if (msb) begin
                if (i == e - 1 && !rf && w == 64) top = 1;
                else r = r ^ (p & m[63:0]);
            end
        end
        rv = '0;
        for (int i = 0; i < w; i++) rv[w-1-i] = r[i];
        if (!rf) word = r << (64 - w);
        else if (w < 64) word = rv << 1;
        else word = rv;
    endfunction

    function automatic string mode_tag(input logic [1:0] ws, input bit rf, input bit er);
        if (er) return "R9";
        if (ws == 2'd2) return rf ? "R5" : "R6";
        return rf ? "R4" : "R2";
    endfunction

    // One run; if poke is set, start is pulsed mid-run with other inputs (R8).
    task automatic run(input logic [63:0] p, input logic [1:0] ws, input int a, input bit rf, input bit poke);
        logic [63:0] ew; bit et, ee; int el, c;
        string tg;
        model(p, ws, a, rf, ew, et, ee, el);
        tg = mode_tag(ws, rf, ee);
        @(negedge clk);
        poly = p; width_sel = ws; exponent = 16'(a); reflect = rf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
        c = 0;
        while (!done && c < 70000) begin
            @(negedge clk);
            c++;
            if (poke && c == 2) begin
                poly = ~p; width_sel = 2'd0; exponent = 16'd3; reflect = ~rf; start = 1'b1;
            end else start = 1'b0;
        end
        start = 1'b0;
        if (poke) check(c == el, "R8 latency under ignored start", 64'(c), 64'(el));
        else      check(c == el, "R7 latency", 64'(c), 64'(el));
        check(const_word == ew, tg, const_word, ew);
        check(top_term == et, "R6 top_term", 64'(top_term), 64'(et));
        check(err == ee, "R9 err", 64'(err), 64'(ee));
        @(negedge clk);
        check(!done && !busy, "R7 single done", 64'({done, busy}), 64'd0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_w;
        int unsigned seed;
        seed = 32'd1729;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check({busy, done, err, top_term} == 4'b0 && const_word == '0, "R10 reset",
              {const_word[59:0], busy, done, err, top_term}, 64'd0);
        // R3 known constant
        run(64'h04C11DB7, 2'd1, 608, 1'b0, 1'b0);
        check(const_word == 64'h8833794C00000000, "R3 known value", const_word, 64'h8833794C00000000);
        // R1 width codes and boundary exponents
        run(64'h1021, 2'd0, 16, 1'b0, 1'b0);
        check(const_word == 64'h0001000000000000, "R2 e=0", const_word, 64'h0001000000000000);
        run(64'h04C11DB7, 2'd1, 0, 1'b1, 1'b0);
        check(const_word == 64'h100000000, "R4 a=0", const_word, 64'h100000000);
        run(64'h42F0E1EBA9EA3693, 2'd2, 0, 1'b1, 1'b0);   // R9 reflected 64 a=0
        run(64'h04C11DB7, 2'd1, 31, 1'b0, 1'b0);          // R9 a<W
        run(64'h1021, 2'd3, 100, 1'b0, 1'b0);             // R1 reserved code -> R9
        run(64'h42F0E1EBA9EA3693, 2'd2, 64, 1'b0, 1'b0);  // R6 e=0
        run(64'h000000000000001B, 2'd2, 200, 1'b0, 1'b0); // R6
        run(64'h42F0E1EBA9EA3693, 2'd2, 1, 1'b1, 1'b0);   // R5 e=0
        run(64'h04C11DB7, 2'd1, 480, 1'b1, 1'b1);         // R8
        // R11 hold between runs
        hold_w = const_word;
        repeat (5) @(negedge clk);
        check(const_word == hold_w && err == 1'b0, "R11 hold", const_word, hold_w);
        // Random mix of all modes
        for (int k = 0; k < 220; k++) begin
            logic [63:0] rp; logic [1:0] rw; int ra; bit rr;
            rp = {$urandom, $urandom};
            rw = 2'($urandom % 4);
            if (rw == 2'd3 && ($urandom % 3) != 0) rw = 2'd1;
            ra = int'($urandom % 700);
            rr = 1'($urandom);
            run(rp, rw, ra, rr, 1'b0);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule